// File: doc/BRIEF.md
# Rotating priority interrupt resolver

This core arbitrates among eight interrupt lines. Each line is captured into a pending register, either on a rising edge or as a level, chosen per line by a trigger-select input. A mask register hides lines from arbitration. An in-service register records which interrupts the processor is currently handling. Priority is counted from a programmable rotation base: the base line ranks highest and the ranking wraps around from it.

The core raises its interrupt output only when the best unmasked pending line strictly outranks the best line in service. When the processor acknowledges, the core reports the winning line number and updates its state. Without automatic end-of-interrupt, the line is marked in service. With automatic end-of-interrupt and rotation enabled, the base moves past the acknowledged line and nothing is marked in service. An end-of-interrupt strobe retires the highest-ranked line in service.

Mask and rotation base are loaded by write strobes. All other configuration arrives as plain inputs. Bus decoding, command parsing and cascading of several cores are done elsewhere.

Top module: `rot_irq_resolver`

## Requirements
- R1: A synchronous reset clears the pending, in-service, mask, previous-level and rotation-base registers to zero.
- R2: On an edge line (`trig_level[i]`=0), the pending bit is set by a 0-to-1 change of `irq_in[i]` between two clock edges. A low input leaves a set pending bit unchanged.
- R3: On a level line (`trig_level[i]`=1), the pending bit equals the input sampled at the last clock edge.
- R4: Line i has rank (i - base) mod 8, where 0 is the best rank. `ack_line` gives the winning line number, which is its rank plus the base, mod 8.
- R5: `int_req` is high only when the best rank among unmasked pending lines is strictly better than the best rank in service. It is low when no unmasked line is pending.
- R6: A `mask_wr` strobe loads `mask_data` into the mask register. A set mask bit (1 = masked) removes that line from arbitration.
- R7: While `skip_cascade` is high, in-service bit 2 is left out of the service-rank comparison.
- R8: `ack` while `int_req` is high, with `auto_end`=0, sets the in-service bit of the line shown on `ack_line`.
- R9: With `auto_end`=1, an acknowledge sets no in-service bit. If `rot_on_auto_end`=1 as well, the base becomes (line + 1) mod 8. Otherwise the base is unchanged.
- R10: An acknowledge clears the pending bit of the winning line only if that line is edge-triggered. Level lines keep their pending bit.
- R11: When `int_req` is low, `ack_line` reads 7 and an `ack` changes no register.
- R12: An `end_irq` strobe clears the in-service bit that has the best rank under the current base. It clears nothing if none is set.
- R13: A `rot_wr` strobe loads `rot_data` as the rotation base.
- R14: When events fall in the same cycle, the following apply:
  - An end-of-interrupt clear and an acknowledge set combine; both are judged on the registers before the edge.
  - A new rising edge on the acknowledged edge line keeps its pending bit set.
  - `rot_wr` overrides the rotation caused by an automatic end-of-interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 8 | Interrupt request inputs |
| trig_level | input | 8 | Per-line trigger select, 1 = level, 0 = rising edge |
| mask_wr | input | 1 | Load strobe for the mask register |
| mask_data | input | 8 | New mask value, 1 = masked |
| rot_wr | input | 1 | Load strobe for the rotation base |
| rot_data | input | 3 | New rotation base |
| auto_end | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_on_auto_end | input | 1 | Rotate base on automatic end-of-interrupt |
| skip_cascade | input | 1 | Leave in-service line 2 out of the service rank |
| ack | input | 1 | Acknowledge strobe |
| end_irq | input | 1 | Non-specific end-of-interrupt strobe |
| int_req | output | 1 | Interrupt request to the processor |
| ack_line | output | 3 | Winning line number, 7 when none |

## Verification
An acknowledge and an end-of-interrupt can land in the same cycle. The bench forces this case with line 2 in service and line 1 pending, then strobes `ack` and `end_irq` together. It then checks that line 2 is retired and line 1 is held, so the interrupt stays low until a second end-of-interrupt. A second case pairs an acknowledge with a fresh rising edge on the same edge-triggered line. Here the bench checks that the request is still pending once service ends. A third case pairs a rotation write with an automatic rotation. The line reported afterwards shows which base won.

// File: rtl/rot_irq_resolver.sv
module rot_irq_resolver #(
  parameter int N = 8,
  parameter int CASCADE_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         irq_in,
  input  logic [N-1:0]         trig_level,
  input  logic                 mask_wr,
  input  logic [N-1:0]         mask_data,
  input  logic                 rot_wr,
  input  logic [$clog2(N)-1:0] rot_data,
  input  logic                 auto_end,
  input  logic                 rot_on_auto_end,
  input  logic                 skip_cascade,
  input  logic                 ack,
  input  logic                 end_irq,
  output logic                 int_req,
  output logic [$clog2(N)-1:0] ack_line
);
  localparam int IDX_W = $clog2(N);
  localparam logic [IDX_W:0] NONE = (IDX_W+1)'(N);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0]     pend_q, serv_q, mask_q, prev_q;
  logic [IDX_W-1:0] base_q;

  function automatic logic [IDX_W:0] top_rank(input logic [N-1:0] vec, input logic [IDX_W-1:0] b);
    logic [IDX_W:0] r;
    r = NONE;
    for (int j = N-1; j >= 0; j--)
      if (vec[b + IDX_W'(j)]) r = (IDX_W+1)'(j);
    return r;
  endfunction

  logic [IDX_W:0]   req_rank, svc_rank, ret_rank;
  logic [IDX_W-1:0] win_line, ret_line;
  logic [N-1:0]     svc_vec, win_oh, ret_oh, rise;
  logic             take;

  assign svc_vec  = skip_cascade ? (serv_q & ~(ONE << CASCADE_LINE)) : serv_q;
  assign req_rank = top_rank(pend_q & ~mask_q, base_q);
  assign svc_rank = top_rank(svc_vec, base_q);
  assign ret_rank = top_rank(serv_q, base_q);

  assign win_line = req_rank[IDX_W-1:0] + base_q;
  assign ret_line = ret_rank[IDX_W-1:0] + base_q;
  assign int_req  = req_rank < svc_rank;
  assign ack_line = int_req ? win_line : {IDX_W{1'b1}};

  assign take   = ack & int_req;
  assign win_oh = take ? (ONE << win_line) : '0;
  assign ret_oh = (end_irq && ret_rank != NONE) ? (ONE << ret_line) : '0;
  assign rise   = irq_in & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      serv_q <= '0;
      mask_q <= '0;
      prev_q <= '0;
      base_q <= '0;
    end else begin
      prev_q <= irq_in;
      pend_q <= (trig_level & irq_in) | (~trig_level & ((pend_q & ~win_oh) | rise));
      serv_q <= (serv_q & ~ret_oh) | (auto_end ? '0 : win_oh);
      if (mask_wr) mask_q <= mask_data;
      if (rot_wr) base_q <= rot_data;
      else if (take && auto_end && rot_on_auto_end) base_q <= win_line + 1'b1;
    end
  end
endmodule

// File: rtl/rot_irq_resolver_chk.sv
module rot_irq_resolver_chk #(
  parameter int N = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     irq_in,
  input logic [N-1:0]     trig_level,
  input logic             auto_end,
  input logic             rot_on_auto_end,
  input logic             rot_wr,
  input logic             ack,
  input logic             end_irq,
  input logic             int_req,
  input logic [IDX_W-1:0] ack_line,
  input logic [N-1:0]     pend,
  input logic [N-1:0]     serv,
  input logic [N-1:0]     mask,
  input logic [N-1:0]     prev,
  input logic [IDX_W-1:0] base
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pend == '0 && serv == '0 && mask == '0 && prev == '0 && base == '0)); // R1
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ack |=> ((~$past(trig_level) & $past(pend) & ~pend) == '0)); // R2
  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pend & $past(trig_level)) == ($past(irq_in) & $past(trig_level)))); // R3
  AST_NO_PEND_NO_INT: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~mask) == '0) |-> !int_req); // R5
  AST_ACK_MARKS_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (ack && int_req && !auto_end) |=> serv[$past(ack_line)]); // R8
  AST_AUTO_ROTATE: assert property (@(posedge clk) disable iff (rst)
    (ack && int_req && auto_end && rot_on_auto_end && !rot_wr) |=> base == IDX_W'($past(ack_line) + 1'b1)); // R9
  AST_IDLE_ACK_NOP: assert property (@(posedge clk) disable iff (rst)
    (ack && !int_req && !end_irq) |=> serv == $past(serv)); // R11
endmodule

bind rot_irq_resolver rot_irq_resolver_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .trig_level(trig_level),
  .auto_end(auto_end), .rot_on_auto_end(rot_on_auto_end), .rot_wr(rot_wr),
  .ack(ack), .end_irq(end_irq), .int_req(int_req), .ack_line(ack_line),
  .pend(pend_q), .serv(serv_q), .mask(mask_q), .prev(prev_q), .base(base_q)
);

// File: tb/rot_irq_resolver_test.sv
module rot_irq_resolver_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst = 1;
  logic [7:0] irq_in = 0, trig_level = 0, mask_data = 0;
  logic       mask_wr = 0, rot_wr = 0, auto_end = 0, rot_on_auto_end = 0;
  logic       skip_cascade = 0, ack = 0, end_irq = 0;
  logic [2:0] rot_data = 0;
  logic       int_req;
  logic [2:0] ack_line;
  int checks = 0, errors = 0;
  bit done = 0;

  rot_irq_resolver uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // {irq_in, mask, base, expected int_req, expected ack_line}, all lines level
  localparam logic [22:0] VEC [10] = '{
    {8'h00, 8'h00, 3'd0, 1'b0, 3'd7},
    {8'h28, 8'h00, 3'd0, 1'b1, 3'd3},
    {8'h28, 8'h00, 3'd4, 1'b1, 3'd5},
    {8'h28, 8'h00, 3'd6, 1'b1, 3'd3},
    {8'h28, 8'h08, 3'd0, 1'b1, 3'd5},
    {8'h28, 8'h28, 3'd0, 1'b0, 3'd7},
    {8'h81, 8'h00, 3'd1, 1'b1, 3'd7},
    {8'h81, 8'h00, 3'd0, 1'b1, 3'd0},
    {8'hFF, 8'h00, 3'd3, 1'b1, 3'd3},
    {8'h01, 8'hFE, 3'd7, 1'b1, 3'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_out(input string tag, input bit e_int, input int e_line);
    chk({tag, " int_req"}, int_req, e_int);
    chk({tag, " ack_line"}, ack_line, e_int ? e_line : 7);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    irq_in = 0; trig_level = 0; mask_wr = 0; mask_data = 0; rot_wr = 0; rot_data = 0;
    auto_end = 0; rot_on_auto_end = 0; skip_cascade = 0; ack = 0; end_irq = 0;
    rst = 1; step(); rst = 0;
  endtask

  task automatic pulse_ack();
    ack = 1; step(); ack = 0;
  endtask

  task automatic pulse_end();
    end_irq = 1; step(); end_irq = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R1: reset clears mask and base loaded just before
    mask_wr = 1; mask_data = 8'hFF; rot_wr = 1; rot_data = 3'd5; step();
    mask_wr = 0; rot_wr = 0;
    rst = 1; trig_level = 8'hFF; irq_in = 8'hFF; step();
    expect_out("R1 in reset", 0, 7);
    rst = 0; irq_in = 8'h21; step();
    expect_out("R1 mask and base cleared", 1, 0);

    // R4 R5 R6: table walk
    do_reset();
    trig_level = 8'hFF;
    for (int k = 0; k < 10; k++) begin
      irq_in = VEC[k][22:15]; mask_wr = 1; mask_data = VEC[k][14:7];
      rot_wr = 1; rot_data = VEC[k][6:4];
      step();
      mask_wr = 0; rot_wr = 0;
      expect_out($sformatf("R4/R6 vector %0d", k), VEC[k][3], int'(VEC[k][2:0]));
    end

    // R2 R8 R10: edge line
    do_reset();
    irq_in = 8'h10; step();
    expect_out("R2 rising edge", 1, 4);
    irq_in = 8'h00; step();
    expect_out("R2 low input holds", 1, 4);
    ack = 1;
    chk("R8 ack_line", ack_line, 4);
    step(); ack = 0;
    expect_out("R8 in service", 0, 7);
    pulse_end();
    expect_out("R10 edge pending cleared", 0, 7);
    irq_in = 8'h10; step();
    expect_out("R2 second edge", 1, 4);

    // R3 R5 R10: level line
    do_reset();
    trig_level = 8'h10; irq_in = 8'h10; step();
    expect_out("R3 level high", 1, 4);
    pulse_ack();
    expect_out("R5 equal rank blocked", 0, 7);
    pulse_end();
    expect_out("R10 level pending kept", 1, 4);
    irq_in = 8'h00; step();
    expect_out("R3 level low", 0, 7);

    // R5: nesting
    do_reset();
    trig_level = 8'hFF; irq_in = 8'h40; step();
    pulse_ack();
    irq_in = 8'hC0; step();
    expect_out("R5 lower rank blocked", 0, 7);
    irq_in = 8'h44; step();
    expect_out("R5 higher rank passes", 1, 2);

    // R7: cascade line skipped
    do_reset();
    trig_level = 8'hFF; irq_in = 8'h04; step();
    pulse_ack();
    expect_out("R7 line 2 in service", 0, 7);
    skip_cascade = 1; step();
    expect_out("R7 skip on, line 2 again", 1, 2);
    skip_cascade = 0; irq_in = 8'h20; step();
    expect_out("R7 skip off blocks line 5", 0, 7);
    skip_cascade = 1; step();
    expect_out("R7 skip on passes line 5", 1, 5);

    // R12: end of interrupt retires best rank only
    do_reset();
    trig_level = 8'hFF; irq_in = 8'h40; step();
    pulse_ack();
    irq_in = 8'h04; step();
    pulse_ack();
    irq_in = 8'h10; step();
    expect_out("R12 blocked by 2", 0, 7);
    pulse_end();
    expect_out("R12 line 2 retired", 1, 4);
    irq_in = 8'h80; step();
    expect_out("R12 line 6 still in service", 0, 7);

    // R9: automatic end with rotation
    do_reset();
    trig_level = 8'hFF; auto_end = 1; rot_on_auto_end = 1; irq_in = 8'h08; step();
    expect_out("R9 before ack", 1, 3);
    pulse_ack();
    irq_in = 8'h28; step();
    expect_out("R9 base moved to 4, no service", 1, 5);
    do_reset();
    trig_level = 8'hFF; auto_end = 1; irq_in = 8'h28; step();
    pulse_ack();
    expect_out("R9 no rotation without enable", 1, 3);

    // R13 R14: rotation write wins over automatic rotation
    do_reset();
    trig_level = 8'hFF; rot_wr = 1; rot_data = 3'd5; irq_in = 8'h28; step();
    rot_wr = 0;
    expect_out("R13 base 5", 1, 5);
    auto_end = 1; rot_on_auto_end = 1; rot_wr = 1; rot_data = 3'd4; ack = 1; step();
    ack = 0; rot_wr = 0;
    expect_out("R14 rot_wr wins", 1, 5);

    // R11: idle acknowledge
    do_reset();
    trig_level = 8'hFF; ack = 1;
    expect_out("R11 idle ack_line", 0, 7);
    step(); ack = 0;
    irq_in = 8'h80; step();
    expect_out("R11 nothing marked", 1, 7);

    // R14: ack and end of interrupt together
    do_reset();
    trig_level = 8'hFF; irq_in = 8'h04; step();
    pulse_ack();
    irq_in = 8'h02; step();
    expect_out("R14 line 1 pending", 1, 1);
    ack = 1; end_irq = 1; step(); ack = 0; end_irq = 0;
    expect_out("R14 line 1 held in service", 0, 7);
    pulse_end();
    expect_out("R14 line 1 retired", 1, 1);

    // R14: new edge on the acknowledged line
    do_reset();
    irq_in = 8'h08; step();
    irq_in = 8'h00; step();
    irq_in = 8'h08; ack = 1;
    chk("R14 edge ack_line", ack_line, 3);
    step(); ack = 0;
    expect_out("R14 edge served", 0, 7);
    pulse_end();
    expect_out("R14 edge request kept", 1, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule